// File: doc/BRIEF.md
# Hardware/Software Selectable Clock Gate

This block controls the gate of one clock. Software reaches it through a single 32-bit control word. The word chooses who owns the gate:

- **Software owner:** the gate follows a stored enable bit.
- **Hardware owner:** the gate follows an external auto-gating request. Turn-on is immediate. Turn-off can be held back by an optional short or long hysteresis window.

The block reports the settled gate state in a read-only status bit, two cycles after the gate itself changes. Software polls that bit to confirm that a change it requested has taken effect. The clock-gating cell is a behavioural model: an enable latched on the falling edge, ANDed with the clock.

A build parameter fixes the variant:

- **Hardware-only:** the owner and enable bits read 0 and ignore writes.
- **Software-only:** the owner bit reads 1 and the gate follows the enable bit.
- **Selectable:** either owner can be chosen at run time.
- **Selectable with no disable:** the gate is always on while software owns it.

A second parameter sets the reset owner of the selectable variants.

There is no data stream, so every pin is a plain control or status pin with no handshake. A write takes effect on the clock edge at which `reg_wr` is sampled high. Writes cannot be refused.

Top module: `clk_gate_ctl`

## Requirements
- R1: Control word layout: bit 0 is the enable, bit 1 is the owner (1 = software, 0 = hardware), bit 2 enables hysteresis, bit 3 selects the long hysteresis window, and bit 8 is the read-only status. All other read bits are 0, and writes to them have no effect.
- R2: Under software ownership in the selectable variant, `gate_en` equals the enable bit from the edge that writes it, and `hw_req` has no effect.
- R3: Under hardware ownership, `gate_en` is high after any edge at which `hw_req` is sampled high, and the enable bit has no effect.
- R4: Under hardware ownership with hysteresis off, `gate_en` falls at the first edge at which `hw_req` is sampled low.
- R5: With hysteresis on, `gate_en` falls at the 4th consecutive low-request edge (short window) or the 16th (long window). A request seen during the window restarts the count.
- R6: Out of reset, the status bit (bit 8) equals the value `gate_en` had two clock edges earlier.
- R7: The hardware-only variant reads bits 1:0 as 0 whatever is written, and its gate follows `hw_req`.
- R8: The software-only variant reads the owner bit as 1 even after a 0 is written, and its gate follows the enable bit while ignoring `hw_req`.
- R9: In the no-disable variant, `gate_en` stays high under software ownership even when the enable bit is 0.
- R10: In reset, the status bit and the hysteresis bits are 0. A selectable gate with the reset-owner parameter set to 1 comes up owned by software with the enable bit at 1 (word 0x3, gate on). With the parameter at 0 it comes up owned by hardware with the enable bit at 0.
- R11: `gclk` pulses on every clock cycle while `gate_en` is high, and does not pulse while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Control word readback, with status in bit 8 |
| hw_req | input | 1 | Auto-gating request from hardware |
| gate_en | output | 1 | Effective gate enable |
| gclk | output | 1 | Gated clock |

## Verification
The hardest situation to reach from the ports is a hysteresis window interrupted just short of expiry. `hw_req` must drop, stay low for exactly one cycle fewer than the window, and return before the count completes. The bench drives the request step by step on falling edges, counting cycles itself. It then checks that the gate survives the interruption and that a full fresh window is needed afterwards. A mid-window change of owner is reached in a similar way, by writing the owner bit while the request is held at a known level.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  typedef enum logic [1:0] {
    GV_HW_ONLY      = 2'd0,
    GV_SW_ONLY      = 2'd1,
    GV_SELECT       = 2'd2,
    GV_SELECT_NODIS = 2'd3
  } gate_variant_e;

  localparam int REG_W     = 32;
  localparam int BIT_EN    = 0;
  localparam int BIT_OWN   = 1;
  localparam int BIT_HEN   = 2;
  localparam int BIT_HLONG = 3;
  localparam int BIT_STAT  = 8;
endpackage

// File: rtl/cgc_regs.sv
module cgc_regs
  import cgc_pkg::*;
#(
  parameter gate_variant_e VARIANT  = GV_SELECT,
  parameter bit            RESET_SW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             en_bit,
  output logic             own_sw,
  output logic             hyst_en,
  output logic             hyst_long
);
  localparam bit EN_RST = (VARIANT == GV_SW_ONLY) ? 1'b1 :
                          (VARIANT == GV_HW_ONLY) ? 1'b0 : RESET_SW;

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  logic hen_q, hlong_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hen_q   <= 1'b0;
      hlong_q <= 1'b0;
    end else if (wr) begin
      hen_q   <= wdata[BIT_HEN];
      hlong_q <= wdata[BIT_HLONG];
    end
  end
  assign hyst_en   = hen_q;
  assign hyst_long = hlong_q;

  generate
    if (VARIANT == GV_HW_ONLY) begin : g_en_fixed
      assign en_bit = 1'b0;
    end else begin : g_en_store
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en_q <= EN_RST;
        else if (wr) en_q <= wdata[BIT_EN];
      end
      assign en_bit = en_q;
    end

    if (VARIANT == GV_HW_ONLY) begin : g_own_hw
      assign own_sw = 1'b0;
    end else if (VARIANT == GV_SW_ONLY) begin : g_own_sw
      assign own_sw = 1'b1;
    end else begin : g_own_store
      logic own_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  own_q <= RESET_SW;
        else if (wr) own_q <= wdata[BIT_OWN];
      end
      assign own_sw = own_q;
    end
  endgenerate
endmodule

// File: rtl/cgc_hyst.sv
module cgc_hyst #(
  parameter int LO_DLY = 4,
  parameter int HI_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic req,
  input  logic hyst_en,
  input  logic hyst_long,
  output logic hw_on
);
  localparam int MAXD = (HI_DLY > LO_DLY) ? HI_DLY : LO_DLY;
  localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam logic [CW-1:0] LO_LAST = CW'(LO_DLY - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HI_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          on_q;
  logic [CW-1:0] last;

  assign last = hyst_long ? HI_LAST : LO_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!active || req) begin
      on_q  <= req;
      cnt_q <= '0;
    end else if (on_q) begin
      if (!hyst_en || cnt_q == last) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hw_on = on_q;
endmodule

// File: rtl/cgc_sync.sv
module cgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sh_q[i] <= 1'b0;
        else if (i == 0) sh_q[i] <= d;
        else             sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cgc_icg.sv
module cgc_icg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_l;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_l <= 1'b0;
    else        en_l <= en;
  end
  assign gclk = clk & en_l;
endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
  import cgc_pkg::*;
#(
  parameter gate_variant_e VARIANT     = GV_SELECT,
  parameter bit            RESET_SW    = 1'b1,
  parameter int            LO_DLY      = 4,
  parameter int            HI_DLY      = 16,
  parameter int            SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             hw_req,
  output logic             gate_en,
  output logic             gclk
);
  logic en_bit, own_sw, hyst_en, hyst_long;
  logic hw_on, sw_gate, status;

  cgc_regs #(.VARIANT(VARIANT), .RESET_SW(RESET_SW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .en_bit(en_bit), .own_sw(own_sw), .hyst_en(hyst_en), .hyst_long(hyst_long)
  );

  cgc_hyst #(.LO_DLY(LO_DLY), .HI_DLY(HI_DLY)) u_hyst (
    .clk(clk), .rst_n(rst_n), .active(!own_sw), .req(hw_req),
    .hyst_en(hyst_en), .hyst_long(hyst_long), .hw_on(hw_on)
  );

  generate
    if (VARIANT == GV_SELECT_NODIS) begin : g_nodis
      assign sw_gate = 1'b1;
    end else begin : g_plain
      assign sw_gate = en_bit;
    end
  endgenerate

  assign gate_en = own_sw ? sw_gate : hw_on;

  cgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gate_en), .q(status)
  );

  cgc_icg u_icg (.clk(clk), .rst_n(rst_n), .en(gate_en), .gclk(gclk));

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[BIT_EN]    = en_bit;
    reg_rdata[BIT_OWN]   = own_sw;
    reg_rdata[BIT_HEN]   = hyst_en;
    reg_rdata[BIT_HLONG] = hyst_long;
    reg_rdata[BIT_STAT]  = status;
  end
endmodule

// File: rtl/cgc_chk.sv
module cgc_chk
  import cgc_pkg::*;
#(
  parameter gate_variant_e VARIANT = GV_SELECT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             hw_req,
  input logic             gate_en
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_STATUS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (reg_rdata[BIT_STAT] == $past(gate_en, 2))); // R6

  AST_HW_TURN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[BIT_OWN] && hw_req && !reg_wr) |=> gate_en); // R3

  AST_OFF_NEEDS_LOW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc >= 2'd1) && $fell(gate_en) && !reg_rdata[BIT_OWN] && !$past(reg_rdata[BIT_OWN]))
      |-> !$past(hw_req)); // R5

  generate
    if (VARIANT == GV_SELECT || VARIANT == GV_SW_ONLY) begin : g_sw
      AST_SW_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (VARIANT == GV_SW_ONLY || reg_wdata[BIT_OWN]))
          |=> (gate_en == $past(reg_wdata[BIT_EN]))); // R2
    end
    if (VARIANT == GV_SELECT_NODIS) begin : g_nd
      AST_NODIS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[BIT_OWN] |-> gate_en); // R9
    end
    if (VARIANT == GV_HW_ONLY) begin : g_ho
      AST_HWONLY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[1:0] == 2'b00)); // R7
    end
    if (VARIANT == GV_SW_ONLY) begin : g_so
      AST_SWONLY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[BIT_OWN]); // R8
    end
  endgenerate
endmodule

bind clk_gate_ctl cgc_chk #(.VARIANT(VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .hw_req(hw_req), .gate_en(gate_en)
);

// File: tb/sim_clk_gate_ctl.sv
`timescale 1ns/1ps
module sim_clk_gate_ctl;
  import cgc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic hw_req = 1'b0;

  logic [31:0] rd0, rd_ho, rd_so, rd_nd;
  logic g0, g_ho, g_so, g_nd;
  logic gc0, gc_ho, gc_so, gc_nd;

  int n_chk = 0;
  int n_fail = 0;
  int gpulse = 0;

  always #2.5 clk = ~clk;

  clk_gate_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd0), .hw_req(hw_req), .gate_en(g0), .gclk(gc0));
  clk_gate_ctl #(.VARIANT(GV_HW_ONLY)) u_ho (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_ho), .hw_req(hw_req), .gate_en(g_ho), .gclk(gc_ho));
  clk_gate_ctl #(.VARIANT(GV_SW_ONLY)) u_so (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_so), .hw_req(hw_req), .gate_en(g_so), .gclk(gc_so));
  clk_gate_ctl #(.VARIANT(GV_SELECT_NODIS), .RESET_SW(1'b0)) u_nd (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_nd), .hw_req(hw_req), .gate_en(g_nd), .gclk(gc_nd));

  always @(posedge gc0) gpulse++;

  // {wr, data[3:0], req, expected u0 gate, expected u_so gate}
  localparam int NV = 9;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 4'h2, 1'b0, 1'b0, 1'b0},
    {1'b0, 4'h0, 1'b1, 1'b0, 1'b0},
    {1'b1, 4'h3, 1'b1, 1'b1, 1'b1},
    {1'b1, 4'h0, 1'b1, 1'b1, 1'b0},
    {1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    {1'b0, 4'h0, 1'b1, 1'b1, 1'b0},
    {1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    {1'b1, 4'h1, 1'b0, 1'b0, 1'b1},
    {1'b1, 4'h3, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic r);
    reg_wr = w;
    reg_wdata = d;
    hw_req = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic h1, h2;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 u0 word in reset", rd0, 32'h3);
    chk("R10 u0 gate in reset", {31'd0, g0}, 32'd1);
    chk("R10 u_nd word in reset", rd_nd, 32'h0);
    chk("R10 u_nd gate in reset", {31'd0, g_nd}, 32'd0);
    chk("R8 u_so word in reset", rd_so, 32'h3);
    chk("R7 u_ho word in reset", rd_ho, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 u0 status after reset", rd0, 32'h103);

    // vector walk: R2 R3 R4 R6 R7 R8
    h2 = 1'b1; h1 = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], {28'd0, VEC[i][6:3]}, VEC[i][2]);
      chk($sformatf("R2/R3/R4 u0 gate step %0d", i), {31'd0, g0}, {31'd0, VEC[i][1]});
      chk($sformatf("R6 u0 status step %0d", i), {31'd0, rd0[8]}, {31'd0, h2});
      chk($sformatf("R7 u_ho gate step %0d", i), {31'd0, g_ho}, {31'd0, VEC[i][2]});
      chk($sformatf("R8 u_so gate step %0d", i), {31'd0, g_so}, {31'd0, VEC[i][0]});
      h2 = h1; h1 = VEC[i][1];
    end

    // R1 reserved bits read 0
    step(1'b1, 32'hFFFF_FEF3, 1'b0);
    chk("R1 u0 reserved bits", rd0 & 32'hFFFF_FEFC, 32'h0);
    chk("R1 u0 low bits", rd0 & 32'hF, 32'h3);

    // R5 short hysteresis
    step(1'b1, 32'h4, 1'b1);
    step(1'b0, 32'h0, 1'b1);
    for (int j = 1; j <= 4; j++) begin
      step(1'b0, 32'h0, 1'b0);
      if (j == 3) chk("R5 short window still on", {31'd0, g0}, 32'd1);
      if (j == 4) chk("R5 short window off at 4", {31'd0, g0}, 32'd0);
      if (j == 4) chk("R7 u_ho short window off at 4", {31'd0, g_ho}, 32'd0);
    end
    // R5 restart by request inside window
    step(1'b0, 32'h0, 1'b1);
    for (int j = 0; j < 3; j++) step(1'b0, 32'h0, 1'b0);
    step(1'b0, 32'h0, 1'b1);
    for (int j = 1; j <= 4; j++) begin
      step(1'b0, 32'h0, 1'b0);
      if (j == 3) chk("R5 restarted window still on", {31'd0, g0}, 32'd1);
      if (j == 4) chk("R5 restarted window off", {31'd0, g0}, 32'd0);
    end
    // R5 long hysteresis
    step(1'b1, 32'hC, 1'b1);
    for (int j = 1; j <= 16; j++) begin
      step(1'b0, 32'h0, 1'b0);
      if (j == 15) chk("R5 long window still on", {31'd0, g0}, 32'd1);
      if (j == 16) chk("R5 long window off at 16", {31'd0, g0}, 32'd0);
    end

    // R7 hardware-only ignores owner/enable writes
    step(1'b1, 32'h3, 1'b0);
    chk("R7 u_ho bits 1:0", rd_ho & 32'h3, 32'h0);
    chk("R7 u_ho gate follows req", {31'd0, g_ho}, 32'd0);

    // R8 software-only owner stays 1, ignores request
    step(1'b1, 32'h0, 1'b1);
    chk("R8 u_so owner bit", {31'd0, rd_so[1]}, 32'd1);
    chk("R8 u_so gate off", {31'd0, g_so}, 32'd0);
    step(1'b0, 32'h0, 1'b1);
    chk("R8 u_so ignores request", {31'd0, g_so}, 32'd0);

    // R9 no-disable stays on under software with enable 0
    step(1'b1, 32'h2, 1'b0);
    chk("R9 u_nd gate on", {31'd0, g_nd}, 32'd1);
    chk("R9 u_nd enable reads 0", {31'd0, rd_nd[0]}, 32'd0);
    step(1'b1, 32'h0, 1'b0);
    chk("R9 u_nd hardware owner off", {31'd0, g_nd}, 32'd0);

    // R11 gated clock pulses
    step(1'b1, 32'h2, 1'b0);
    step(1'b0, 32'h0, 1'b0);
    gpulse = 0;
    repeat (8) @(negedge clk);
    chk("R11 no pulses while off", gpulse, 32'd0);
    step(1'b1, 32'h3, 1'b0);
    step(1'b0, 32'h0, 1'b0);
    gpulse = 0;
    repeat (8) @(negedge clk);
    chk("R11 pulses while on", gpulse, 32'd8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule